// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a bus master that runs single-byte read and write transfers to memory or to I/O space over a bus where the low address byte and the data byte share one set of pins. A requester presents an address, a direction, a space select and, for writes, a data byte. The sequencer then runs a fixed three-state cycle on the bus, with one clock per state. In the first state it drives the address, with the low byte on the shared lines and an address-latch strobe that an external latch uses to capture that byte. It then turns the shared lines into the data path and drives an active-low read or write strobe for the remaining two states.

Read data is sampled from the shared lines as the last state closes and is held in an output register. A one-clock completion pulse follows each cycle. A request is taken only while the sequencer is idle. A request presented in the completion cycle starts a new cycle on the next clock, so two transfers can be issued back to back with a single idle clock between them.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset and whenever idle, the address-latch strobe `ale` is 0, both `rd_n` and `wr_n` are 1, `done` is 0 and the shared lines `ad` are not driven; `rdata` resets to 0.
- R2: In the first clock after a request is taken (T1), `ale` is 1, `addr_hi` carries address bits 15..8, `ad` carries address bits 7..0, and both strobes are 1.
- R3: `io_m` is 0 for a memory request and 1 for an I/O request, and holds that value from T1 through T3.
- R4: In T2 and T3, `ale` is 0 and exactly one strobe is 0: `rd_n` when `req_write` was 0, `wr_n` when `req_write` was 1.
- R5: In a read cycle the sequencer releases `ad` during T2 and T3, so the value seen there is the byte the target drives.
- R6: In a write cycle `ad` carries the write byte for as long as `wr_n` is 0 (T2 and T3).
- R7: Each cycle lasts exactly three clocks. In the clock after T3 both strobes are 1 and `done` is 1 for that single clock.
- R8: At the end of T3 of a read, the byte on `ad` is loaded into `rdata`, which then holds until the next read completes. Write cycles leave it unchanged.
- R9: `req_valid` asserted while a cycle is in progress is ignored: no further cycle follows.
- R10: A request presented in the clock where `done` is 1 is taken, and its T1 starts on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 8 | Byte to write |
| addr_hi | output | 8 | Upper address byte |
| ad | inout | 8 | Shared low-address / data lines |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | Space select: 0 memory, 1 I/O |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-clock completion pulse |

## Verification
Memory and I/O reads and writes are run at addresses whose high and low bytes differ. This shows whether `addr_hi` and `ad` are swapped and whether `io_m` follows the request. The target returns a byte derived from the whole address, and an idle bus keeper drives a fixed pattern, so a sequencer that keeps driving `ad` in a read or while idle is visible as a wrong byte. A write placed between reads shows that `rdata` is held, a request pulsed mid-cycle tests R9, and a request issued in the `done` clock tests the back-to-back start.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2,
        ST_T3   = 2'd3
    } tstate_e;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    output tstate_e           state,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_write,
    output logic              cyc_io,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic              done
);
    typedef struct packed {
        tstate_e           st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              io;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_T1;
                    seq_d.addr  = req_addr;
                    seq_d.wr    = req_write;
                    seq_d.io    = req_io;
                    seq_d.wdata = req_wdata;
                end
            end
            ST_T1: seq_d.st = ST_T2;
            ST_T2: seq_d.st = ST_T3;
            ST_T3: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, wr: 1'b0, io: 1'b0, wdata: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state     = seq_q.st;
    assign cyc_addr  = seq_q.addr;
    assign cyc_write = seq_q.wr;
    assign cyc_io    = seq_q.io;
    assign cyc_wdata = seq_q.wdata;
    assign done      = seq_q.done;
endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  tstate_e           state,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic              cyc_io,
    input  logic [DATA_W-1:0] cyc_wdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out
);
    logic strobe_phase;

    always_comb begin
        strobe_phase = (state == ST_T2) || (state == ST_T3);
        ale          = (state == ST_T1);
        rd_n         = !(strobe_phase && !cyc_write);
        wr_n         = !(strobe_phase && cyc_write);
        io_m         = cyc_io;
        addr_hi      = cyc_addr[ADDR_W-1:DATA_W];
        ad_oe        = ale || (strobe_phase && cyc_write);
        ad_out       = ale ? cyc_addr[DATA_W-1:0] : cyc_wdata;
    end
endmodule

// File: rtl/mbs_capture.sv
module mbs_capture
    import mbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           state,
    input  logic              cyc_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (state == ST_T3 && !cyc_write) begin
            rdata_d = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [HI_W-1:0]   addr_hi,
    inout  wire  [DATA_W-1:0] ad,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    tstate_e           state;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_write;
    logic              cyc_io;
    logic [DATA_W-1:0] cyc_wdata;
    logic              ad_oe;
    logic [DATA_W-1:0] ad_out;

    mbs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_io    (req_io),
        .req_wdata (req_wdata),
        .state     (state),
        .cyc_addr  (cyc_addr),
        .cyc_write (cyc_write),
        .cyc_io    (cyc_io),
        .cyc_wdata (cyc_wdata),
        .done      (done)
    );

    mbs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state     (state),
        .cyc_addr  (cyc_addr),
        .cyc_write (cyc_write),
        .cyc_io    (cyc_io),
        .cyc_wdata (cyc_wdata),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_m      (io_m),
        .addr_hi   (addr_hi),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out)
    );

    assign ad = ad_oe ? ad_out : {DATA_W{1'bz}};

    mbs_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .cyc_write (cyc_write),
        .ad_in     (ad),
        .rdata     (rdata)
    );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic              io_m,
    input logic              done,
    input logic [DATA_W-1:0] ad
);
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));

    assert_space_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(io_m));

    assert_wdata_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(ad));

    assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!rd_n || !wr_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind mux_bus_seq mbs_checker #(.DATA_W(DATA_W)) u_mbs_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .io_m  (io_m),
    .done  (done),
    .ad    (ad)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEEPER = 8'hC3;

    typedef struct {
        logic        wr;
        logic        io;
        logic [15:0] addr;
        logic [7:0]  data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  addr_hi;
    wire  [7:0]  ad;
    logic        ale, rd_n, wr_n, io_m, done;
    logic [7:0]  rdata;

    int          vectors = 0;
    int          fails = 0;
    bit          finished = 1'b0;
    item_t       expq[$];
    logic [15:0] lat_addr = '0;
    logic [7:0]  last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .addr_hi(addr_hi), .ad(ad), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .rdata(rdata), .done(done)
    );

    function automatic logic [7:0] tgt_byte(input logic [15:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h5A;
    endfunction

    // target answers reads; keeper holds a pattern while nobody should drive
    assign ad = !rd_n ? tgt_byte(lat_addr) :
                (rd_n && wr_n && !ale) ? KEEPER : 8'bz;

    always @(negedge clk) if (ale) lat_addr <= {addr_hi, ad};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic io, input logic [15:0] a, input logic [7:0] d);
        item_t it;
        it.wr = w; it.io = io; it.addr = a;
        it.data = w ? d : tgt_byte(a);
        expq.push_back(it);
        req_write = w; req_io = io; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (ale) begin
                item_t it;
                if (expq.size() == 0) begin
                    chk("R9 unexpected cycle", 16'd1, 16'd0);
                    continue;
                end
                it = expq.pop_front();
                chk("R2 addr_hi", {8'h0, addr_hi}, {8'h0, it.addr[15:8]});
                chk("R2 ad low addr", {8'h0, ad}, {8'h0, it.addr[7:0]});
                chk("R2 strobes idle in T1", {14'h0, rd_n, wr_n}, 16'h3);
                chk("R3 io_m T1", {15'h0, io_m}, {15'h0, it.io});
                for (int t = 2; t <= 3; t++) begin
                    @(negedge clk);
                    chk("R4 ale low", {15'h0, ale}, 16'h0);
                    chk("R4 strobes", {14'h0, rd_n, wr_n}, it.wr ? 16'h2 : 16'h1);
                    chk("R3 io_m held", {15'h0, io_m}, {15'h0, it.io});
                    chk("R7 no early done", {15'h0, done}, 16'h0);
                    if (it.wr) chk("R6 write byte on ad", {8'h0, ad}, {8'h0, it.data});
                    else       chk("R5 ad released in read", {8'h0, ad}, {8'h0, it.data});
                end
                @(negedge clk);
                chk("R7 done after T3", {15'h0, done}, 16'h1);
                chk("R7 strobes released", {14'h0, rd_n, wr_n}, 16'h3);
                chk("R1 ad released after cycle", {8'h0, ad}, {8'h0, KEEPER});
                if (!it.wr) last_rd = it.data;
                chk("R8 rdata", {8'h0, rdata}, {8'h0, last_rd});
            end else begin
                chk("R1 idle strobes", {13'h0, rd_n, wr_n, ale}, 16'h6);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ale/strobes", {13'h0, ale, rd_n, wr_n}, 16'h3);
        chk("R1 reset done", {15'h0, done}, 16'h0);
        chk("R1 reset rdata", {8'h0, rdata}, 16'h0);
        chk("R1 reset ad released", {8'h0, ad}, {8'h0, KEEPER});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(1'b0, 1'b0, 16'h12A7, 8'h00); wait_done(); @(negedge clk);
        issue(1'b1, 1'b0, 16'hBE05, 8'h9C); wait_done(); @(negedge clk);
        issue(1'b0, 1'b1, 16'h0044, 8'h00); wait_done(); @(negedge clk);
        issue(1'b1, 1'b1, 16'hFF80, 8'h3E); wait_done(); @(negedge clk);
        issue(1'b0, 1'b0, 16'h0000, 8'h00); wait_done(); @(negedge clk);
        issue(1'b0, 1'b1, 16'hFFFF, 8'h00); wait_done(); @(negedge clk);

        // R9: request pulsed mid-cycle must not start another cycle
        issue(1'b1, 1'b0, 16'h5AA5, 8'h71);
        req_addr = 16'h7777; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (3) begin
            @(negedge clk);
            chk("R9 no cycle from busy request", {15'h0, ale}, 16'h0);
        end

        // R10: request in the done clock starts next clock
        issue(1'b0, 1'b0, 16'h3311, 8'h00); wait_done();
        issue(1'b1, 1'b1, 16'hC00C, 8'hE1);
        chk("R10 back-to-back T1", {15'h0, ale}, 16'h1);
        wait_done();
        issue(1'b0, 1'b1, 16'h8421, 8'h00);
        chk("R10 back-to-back after write", {15'h0, ale}, 16'h1);
        wait_done();

        repeat (4) @(negedge clk);
        chk("R7 all cycles completed", 16'(expq.size()), 16'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule